// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming Ethernet frame, presented one byte per cycle with start-of-frame and end-of-frame markers, and stores it in a circular receive area of a byte-wide local memory. The memory is organised in 256-byte pages. The ring is bounded by a first page and a one-past-last page. A write pointer page (the current page) and a read-side boundary page set how much room is free.

When a frame starts, the block first checks whether a worst-case frame would fit. It refuses the frame if the receiver is halted or the ring has no room. It then filters the frame on its destination address, using promiscuous, broadcast, multicast-hash and exact station-address rules. The frame is only written to memory once it has passed the filter.

An accepted frame's data is stored four bytes into its first page, with wraparound at the ring's end. After the last byte, a four-byte header is written at the start of that first page. The current page then advances to the page after the frame, the status byte is updated and a one-cycle completion pulse is raised.

The frame check sequence and the multicast hash CRC are computed outside this block. The storage array is also outside it.

Top module: `rx_ring_writer`

## Requirements
- R1: While `cmd_stop` is high at a frame's start byte, the frame is refused: no memory write, no change of `cur_pg` or `rx_status`, no `rx_done`.
- R2: A frame is refused when `ring_stop_pg` is less than or equal to `ring_start_pg`.
- R3: Free space in pages is `bound_pg - cur_pg` when `cur_pg < bound_pg`, and otherwise `(ring_stop_pg - ring_start_pg) - (cur_pg - bound_pg)`. A frame is refused when that space times 256 is below 1518 bytes, so 5 free pages refuse and 6 accept.
- R4: With `rx_cfg` bit 4 set (promiscuous), every admitted frame of at least 6 bytes is stored, whatever its destination.
- R5: Otherwise, a destination of six 0xFF bytes is stored only when `rx_cfg` bit 2 is set.
- R6: Otherwise, a destination whose first byte has bit 0 set is stored only when `rx_cfg` bit 3 is set and bit k of `mcast_hash` is 1, where k = `dest_crc[31:26]`. Bit k is bit k%8 of hash byte k/8, and hash byte j occupies `mcast_hash[8j+7:8j]`.
- R7: Any other destination is stored only when all six bytes equal `station_addr`. Byte j, the j-th byte received, occupies `station_addr[8j+7:8j]`.
- R8: Data byte i of a stored frame is written at address `cur_pg*256 + 4 + i`. The write address that reaches `ring_stop_pg*256` is replaced by `ring_start_pg*256`.
- R9: Header bytes are written after the data, at `cur_pg*256 + 0..3`, in this order: status (0x01, OR 0x20 when the first destination byte has bit 0 set), next page, stored length low byte, stored length high byte. The stored length is the frame length plus 4.
- R10: The next page is `cur_pg + (stored_length + 4 + 255) / 256`. `ring_stop_pg - ring_start_pg` is subtracted from it when the sum is at or above `ring_stop_pg`.
- R11: After the last header write, `cur_pg` takes the next page, `rx_status` takes the status byte and `rx_done` is high for exactly one cycle. After reset, `cur_pg` and `rx_status` are 0 and no write is issued.
- R12: A frame that fails the filter, and a frame shorter than 6 bytes, is consumed with no memory write and no change to `cur_pg` or `rx_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| cmd_stop | input | 1 | Receiver halted |
| rx_cfg | input | 8 | Filter configuration (bits 2, 3, 4) |
| ring_start_pg | input | PG_W | First page of the ring |
| ring_stop_pg | input | PG_W | Page one past the ring's end |
| bound_pg | input | PG_W | Boundary page held by the reader |
| cur_ld | input | 1 | Load `cur_ld_pg` into the current page |
| cur_ld_pg | input | PG_W | Current page value to load |
| station_addr | input | 48 | Own station address, first byte in bits 7:0 |
| mcast_hash | input | HASH_BITS | Multicast hash filter |
| dest_crc | input | CRC_W | CRC over the destination, valid while the 6th byte is presented |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | PG_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| cur_pg | output | PG_W | Current page |
| rx_status | output | 8 | Status of the last stored frame |
| rx_done | output | 1 | One-cycle pulse when a frame is stored |

## Verification
The hardest situations to reach are the ones at the ring's edges. In one, a frame's data runs past the last page and must continue at the first page while the next-page value also wraps. In the other, the free space sits exactly on either side of the 1518-byte threshold. The bench loads the current page into the last page of the ring, then sends a 300-byte frame so that the data write address and the next page both wrap. It then places the current page 5 and then 6 pages below the boundary, so that one frame is refused and the next is accepted. The scoreboard predicts every write address independently, so a wrong wrap point or a wrong header ordering shows up as an address or data mismatch.

// File: rtl/rxr_pkg.sv
// Shared constants and the controller state type for the receive ring writer.
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RECV  = 3'd1,
        S_SKIP  = 3'd2,
        S_DRAIN = 3'd3,
        S_HDR   = 3'd4
    } rx_state_e;

    localparam int DEST_BYTES = 6;     // destination address length
    localparam int HDR_BYTES  = 4;     // header in front of each frame
    localparam int FCS_BYTES  = 4;     // room reserved for the check sequence
    localparam int PAGE_SH    = 8;     // 256-byte pages

    localparam int CFG_BCAST   = 2;
    localparam int CFG_MCAST   = 3;
    localparam int CFG_PROMISC = 4;

    localparam logic [7:0] ST_RX_OK = 8'h01;
    localparam logic [7:0] ST_GROUP = 8'h20;

endpackage

// File: rtl/rxr_space.sv
// Ring admission check.
// Decides from the ring bounds and the current and boundary pages whether a
// worst-case frame plus its header still fits. Purely combinational.
// Assumes the pages are stable while a start-of-frame byte is judged.
module rxr_space #(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514
) (
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bnd_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            full
);
    import rxr_pkg::*;

    localparam int NEED_BYTES = MAX_FRAME + HDR_BYTES;

    int s_i, e_i, b_i, c_i, free_pg;

    // Free pages between writer and reader, then compare against the need.
    always_comb begin
        s_i = int'(start_pg);
        e_i = int'(stop_pg);
        b_i = int'(bnd_pg);
        c_i = int'(cur_pg);
        if (c_i < b_i) free_pg = b_i - c_i;
        else           free_pg = (e_i - s_i) - (c_i - b_i);
        full = (e_i <= s_i) || ((free_pg * (1 << PAGE_SH)) < NEED_BYTES);
    end

endmodule

// File: rtl/rxr_filter.sv
// Destination address filter.
// Applies promiscuous, broadcast, multicast-hash and exact-match rules to a
// six-byte destination (first byte in the low bits). Combinational.
// Assumes the hash CRC input belongs to the same destination.
module rxr_filter #(
    parameter int HASH_BITS = 64,
    parameter int CRC_W     = 32
) (
    input  logic [47:0]          dest,
    input  logic [47:0]          station,
    input  logic [7:0]           cfg,
    input  logic [HASH_BITS-1:0] hash,
    input  logic [CRC_W-1:0]     crc,
    output logic                 pass,
    output logic                 group
);
    import rxr_pkg::*;

    localparam int IDX_W = $clog2(HASH_BITS);

    logic [IDX_W-1:0] idx;
    logic             is_bcast;
    logic             unused_crc_low;

    assign idx            = crc[CRC_W-1 -: IDX_W];
    assign unused_crc_low = ^crc[CRC_W-IDX_W-1:0];
    assign is_bcast       = &dest;
    assign group          = dest[0];

    // Rule priority: promiscuous, then broadcast, then group, then exact match.
    always_comb begin
        if (cfg[CFG_PROMISC])  pass = 1'b1;
        else if (is_bcast)     pass = cfg[CFG_BCAST];
        else if (group)        pass = cfg[CFG_MCAST] & hash[idx];
        else                   pass = (dest == station);
    end

endmodule

// File: rtl/rxr_nextpg.sv
// Next-page calculator.
// Rounds the stored length plus check-sequence room up to whole pages, adds
// them to the frame's first page and folds the result back into the ring.
// Assumes a frame never spans more than the ring once.
module rxr_nextpg #(
    parameter int PG_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic [PG_W-1:0]  base_pg,
    input  logic [PG_W-1:0]  start_pg,
    input  logic [PG_W-1:0]  stop_pg,
    input  logic [LEN_W-1:0] stored_len,
    output logic [PG_W-1:0]  next_pg
);
    import rxr_pkg::*;

    localparam int SW = PG_W + 1;

    logic [LEN_W:0] span;
    logic [LEN_W:0] pages_w;
    logic [SW-1:0]  sum;
    logic [SW-1:0]  folded;

    // Page count, raw sum, then one fold when the sum reaches the stop page.
    always_comb begin
        span    = {1'b0, stored_len} + (LEN_W+1)'(FCS_BYTES + (1 << PAGE_SH) - 1);
        pages_w = span >> PAGE_SH;
        sum     = {1'b0, base_pg} + SW'(pages_w);
        if (sum >= {1'b0, stop_pg})
            folded = sum - ({1'b0, stop_pg} - {1'b0, start_pg});
        else
            folded = sum;
        next_pg = folded[PG_W-1:0];
    end

endmodule

// File: rtl/rx_ring_writer.sv
// Receive ring writer.
// Accepts a byte stream framed by start/end markers, admits a frame only if
// the ring has room and the receiver runs, filters on the destination, and
// writes accepted data four bytes into the current page. The header follows
// once the length is known. Data is delayed through a six-byte line so no
// byte is written before the filter decision.
// Assumes: at least DEST_BYTES+HDR_BYTES+1 idle cycles between frames,
// dest_crc valid while the sixth byte is presented, ring inputs stable
// during a frame.
module rx_ring_writer #(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1514,
    parameter int HASH_BITS = 64,
    parameter int CRC_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_data,
    input  logic                 cmd_stop,
    input  logic [7:0]           rx_cfg,
    input  logic [PG_W-1:0]      ring_start_pg,
    input  logic [PG_W-1:0]      ring_stop_pg,
    input  logic [PG_W-1:0]      bound_pg,
    input  logic                 cur_ld,
    input  logic [PG_W-1:0]      cur_ld_pg,
    input  logic [47:0]          station_addr,
    input  logic [HASH_BITS-1:0] mcast_hash,
    input  logic [CRC_W-1:0]     dest_crc,
    output logic                 mem_we,
    output logic [PG_W+7:0]      mem_addr,
    output logic [7:0]           mem_wdata,
    output logic [PG_W-1:0]      cur_pg,
    output logic [7:0]           rx_status,
    output logic                 rx_done
);
    import rxr_pkg::*;

    localparam int AW = PG_W + PAGE_SH;
    localparam logic [LEN_W-1:0] DEST_L = LEN_W'(DEST_BYTES);

    rx_state_e        state;
    logic [7:0]       dly [DEST_BYTES];
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] flen;
    logic [PG_W-1:0]  hpg;
    logic [AW-1:0]    wptr;
    logic             grp;
    logic [2:0]       dcnt;
    logic [1:0]       hcnt;

    logic             ring_full;
    logic             f_pass;
    logic             f_group;
    logic [47:0]      dest;
    logic [PG_W-1:0]  nxt_pg;
    logic [LEN_W-1:0] stored_len;
    logic [AW-1:0]    winc;
    logic [AW-1:0]    wnext;
    logic [7:0]       stat_byte;
    logic [7:0]       hdr_byte;

    // Destination as seen while its last byte is on the input.
    genvar g;
    generate
        for (g = 0; g < DEST_BYTES - 1; g++) begin : g_dest
            assign dest[8*g +: 8] = dly[g+1];
        end
    endgenerate
    assign dest[8*DEST_BYTES-1 -: 8] = in_data;

    rxr_space #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME)) u_space (
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .bnd_pg   (bound_pg),
        .cur_pg   (cur_pg),
        .full     (ring_full)
    );

    rxr_filter #(.HASH_BITS(HASH_BITS), .CRC_W(CRC_W)) u_filter (
        .dest    (dest),
        .station (station_addr),
        .cfg     (rx_cfg),
        .hash    (mcast_hash),
        .crc     (dest_crc),
        .pass    (f_pass),
        .group   (f_group)
    );

    assign stored_len = flen + LEN_W'(HDR_BYTES);

    rxr_nextpg #(.PG_W(PG_W), .LEN_W(LEN_W)) u_next (
        .base_pg    (hpg),
        .start_pg   (ring_start_pg),
        .stop_pg    (ring_stop_pg),
        .stored_len (stored_len),
        .next_pg    (nxt_pg)
    );

    // Write pointer step with wrap from the stop page back to the start page.
    always_comb begin
        winc  = wptr + AW'(1);
        wnext = (winc == {ring_stop_pg, 8'h00}) ? {ring_start_pg, 8'h00} : winc;
    end

    // Header byte for the current header slot.
    always_comb begin
        stat_byte = ST_RX_OK | (grp ? ST_GROUP : 8'h00);
        case (hcnt)
            2'd0:    hdr_byte = stat_byte;
            2'd1:    hdr_byte = 8'(nxt_pg);
            2'd2:    hdr_byte = stored_len[7:0];
            default: hdr_byte = stored_len[15:8];
        endcase
    end

    // Controller: admission, delayed data writes, drain and header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            flen      <= '0;
            hpg       <= '0;
            wptr      <= '0;
            grp       <= 1'b0;
            dcnt      <= '0;
            hcnt      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cur_pg    <= '0;
            rx_status <= '0;
            rx_done   <= 1'b0;
            for (int i = 0; i < DEST_BYTES; i++) dly[i] <= '0;
        end else begin
            mem_we  <= 1'b0;
            rx_done <= 1'b0;
            if (cur_ld) cur_pg <= cur_ld_pg;
            case (state)
                S_IDLE: begin
                    if (in_valid && in_sof) begin
                        if (!cmd_stop && !ring_full) begin
                            for (int i = 0; i < DEST_BYTES - 1; i++) dly[i] <= dly[i+1];
                            dly[DEST_BYTES-1] <= in_data;
                            cnt  <= LEN_W'(1);
                            hpg  <= cur_pg;
                            wptr <= {cur_pg, 8'(HDR_BYTES)};
                            if (!in_eof) state <= S_RECV;
                        end else if (!in_eof) begin
                            state <= S_SKIP;
                        end
                    end
                end
                S_RECV: begin
                    if (in_valid) begin
                        for (int i = 0; i < DEST_BYTES - 1; i++) dly[i] <= dly[i+1];
                        dly[DEST_BYTES-1] <= in_data;
                        cnt <= cnt + LEN_W'(1);
                        if (cnt >= DEST_L) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= wptr;
                            mem_wdata <= dly[0];
                            wptr      <= wnext;
                        end
                        if (cnt == DEST_L - LEN_W'(1)) grp <= f_group;
                        if (cnt == DEST_L - LEN_W'(1) && !f_pass) begin
                            state <= in_eof ? S_IDLE : S_SKIP;
                        end else if (in_eof) begin
                            if (cnt < DEST_L - LEN_W'(1)) begin
                                state <= S_IDLE;
                            end else begin
                                state <= S_DRAIN;
                                flen  <= cnt + LEN_W'(1);
                                dcnt  <= '0;
                            end
                        end
                    end
                end
                S_SKIP: begin
                    if (in_valid && in_eof) state <= S_IDLE;
                end
                S_DRAIN: begin
                    for (int i = 0; i < DEST_BYTES - 1; i++) dly[i] <= dly[i+1];
                    dly[DEST_BYTES-1] <= '0;
                    mem_we    <= 1'b1;
                    mem_addr  <= wptr;
                    mem_wdata <= dly[0];
                    wptr      <= wnext;
                    dcnt      <= dcnt + 3'd1;
                    if (dcnt == 3'(DEST_BYTES - 1)) begin
                        state <= S_HDR;
                        hcnt  <= '0;
                    end
                end
                S_HDR: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {hpg, 6'b0, hcnt};
                    mem_wdata <= hdr_byte;
                    hcnt      <= hcnt + 2'd1;
                    if (hcnt == 2'd3) begin
                        cur_pg    <= nxt_pg;
                        rx_status <= stat_byte;
                        rx_done   <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_STOP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_valid && in_sof && cmd_stop) |=> (state != S_RECV)); // R1
    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= {ring_start_pg, 8'h00}) && (mem_addr < {ring_stop_pg, 8'h00})); // R8
    AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (cur_pg >= ring_start_pg) && (cur_pg < ring_stop_pg)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R11
    AST_STATUS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> rx_status[0]); // R11
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) && $past(state == S_SKIP) |-> !mem_we); // R12

endmodule

// File: tb/rx_ring_writer_test.sv
// Scoreboard bench: the frame driver queues the expected memory writes,
// a monitor pops and compares every write the design issues.
module rx_ring_writer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cmd_stop = 1'b0;
    logic [7:0]  rx_cfg = '0;
    logic [7:0]  ring_start_pg = 8'h40, ring_stop_pg = 8'h80, bound_pg = 8'h40;
    logic        cur_ld = 1'b0;
    logic [7:0]  cur_ld_pg = '0;
    logic [47:0] station_addr = 48'h55_44_33_22_11_02;
    logic [63:0] mcast_hash = '0;
    logic [31:0] dest_crc = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic [7:0]  rx_status;
    logic        rx_done;

    int tests = 0, fails = 0, done_cnt = 0;
    logic [23:0] exp_q[$];
    logic [7:0]  frm[$];
    logic [7:0]  m_cur = '0, m_status = '0;
    string       cur_req = "R11";

    rx_ring_writer uut (
        .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data, .cmd_stop, .rx_cfg,
        .ring_start_pg, .ring_stop_pg, .bound_pg, .cur_ld, .cur_ld_pg,
        .station_addr, .mcast_hash, .dest_crc, .mem_we, .mem_addr, .mem_wdata,
        .cur_pg, .rx_status, .rx_done
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each write against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done) done_cnt++;
            if (mem_we) begin
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s unexpected write: actual %h expected none", cur_req, {mem_addr, mem_wdata});
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    if ({mem_addr, mem_wdata} !== e) begin
                        fails++;
                        $display("FAIL %s write: actual %h expected %h", cur_req, {mem_addr, mem_wdata}, e);
                    end
                end
            end
        end
    end

    task automatic build(input logic [47:0] dst, input int len, input int seed);
        frm.delete();
        for (int i = 0; i < len; i++) begin
            if (i < 6) frm.push_back(dst[8*i +: 8]);
            else       frm.push_back(8'((i * 7 + seed) & 8'hFF));
        end
    endtask

    task automatic load_cur(input logic [7:0] v);
        @(negedge clk);
        cur_ld = 1'b1; cur_ld_pg = v;
        @(negedge clk);
        cur_ld = 1'b0;
        m_cur = v;
    endtask

    task automatic send(input bit exp_ok, input string req);
        int d0, n, total, pages, nxt;
        logic [15:0] a;
        logic [7:0] st;
        cur_req = req;
        d0 = done_cnt;
        n = frm.size();
        total = n + 4;
        pages = (total + 4 + 255) / 256;
        nxt = int'(m_cur) + pages;
        if (nxt >= int'(ring_stop_pg)) nxt = nxt - (int'(ring_stop_pg) - int'(ring_start_pg));
        st = 8'h01 | (frm[0][0] ? 8'h20 : 8'h00);
        if (exp_ok) begin
            a = {m_cur, 8'h04};
            for (int i = 0; i < n; i++) begin
                exp_q.push_back({a, frm[i]});
                a = a + 16'd1;
                if (a == {ring_stop_pg, 8'h00}) a = {ring_start_pg, 8'h00};
            end
            exp_q.push_back({m_cur, 8'h00, st});
            exp_q.push_back({m_cur, 8'h01, 8'(nxt)});
            exp_q.push_back({m_cur, 8'h02, 8'(total)});
            exp_q.push_back({m_cur, 8'h03, 8'(total >> 8)});
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = frm[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (20) @(negedge clk);
        if (exp_ok) begin
            m_cur = 8'(nxt);
            m_status = st;
        end
        chk(req, "cur_pg", cur_pg, m_cur);
        chk(req, "rx_status", rx_status, m_status);
        chk(req, "done pulses", done_cnt - d0, exp_ok ? 1 : 0);
        chk(req, "pending writes", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset cur_pg", cur_pg, 8'h00);
        chk("R11", "reset rx_status", rx_status, 8'h00);
        chk("R11", "reset mem_we", mem_we, 1'b0);

        load_cur(8'h40);
        // R7 R8 R9 R10: matching unicast stored
        build(48'h55_44_33_22_11_02, 64, 1); send(1'b1, "R7");
        // R7 R12: one byte differs
        build(48'h56_44_33_22_11_02, 64, 2); send(1'b0, "R12");
        // R5: broadcast refused, then accepted
        build(48'hFF_FF_FF_FF_FF_FF, 100, 3); send(1'b0, "R5");
        rx_cfg = 8'h04;
        build(48'hFF_FF_FF_FF_FF_FF, 100, 4); send(1'b1, "R5");
        // R6: multicast hash, index 42 from crc[31:26]
        rx_cfg = 8'h08; dest_crc = 32'hA800_0000; mcast_hash = 64'h1 << 42;
        build(48'h01_00_00_5E_00_01, 80, 5); send(1'b1, "R6");
        mcast_hash = ~(64'h1 << 42);
        build(48'h01_00_00_5E_00_01, 80, 6); send(1'b0, "R6");
        rx_cfg = 8'h04; mcast_hash = 64'h1 << 42;
        build(48'h01_00_00_5E_00_01, 80, 7); send(1'b0, "R6");
        // R4: promiscuous takes a foreign unicast
        rx_cfg = 8'h10;
        build(48'h99_88_77_66_55_04, 70, 8); send(1'b1, "R4");
        // R1: halted receiver
        cmd_stop = 1'b1;
        build(48'h55_44_33_22_11_02, 70, 9); send(1'b0, "R1");
        cmd_stop = 1'b0;
        // R2: degenerate ring
        ring_stop_pg = 8'h40;
        build(48'h55_44_33_22_11_02, 70, 10); send(1'b0, "R2");
        ring_stop_pg = 8'h80;
        // R3: 5 free pages refuse, 6 accept
        load_cur(8'h50); bound_pg = 8'h55;
        build(48'h55_44_33_22_11_02, 60, 11); send(1'b0, "R3");
        bound_pg = 8'h56;
        build(48'h55_44_33_22_11_02, 60, 12); send(1'b1, "R3");
        // R8 R10: data and next page wrap
        load_cur(8'h7F); bound_pg = 8'h70;
        build(48'h99_88_77_66_55_04, 300, 13); send(1'b1, "R10");
        // R12: too short; R8: exactly six bytes
        build(48'h99_88_77_66_55_04, 4, 14); send(1'b0, "R12");
        build(48'h99_88_77_66_55_04, 6, 15); send(1'b1, "R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule